// File: doc/BRIEF.md
# Clock Mode Latch and Loss-of-Clock Status

This block settles which of four system clock modes a chip runs in, and it keeps the status bit that software polls to learn whether the clocks have failed. Three strap pins are captured on every clock cycle while the system reset is low. Their last captured value is decoded into a one-hot mode vector, and that vector stays fixed from reset release until the next reset. If the straps move while reset is still held, the block reports a loss of lock for one cycle, because the clock source would switch under the logic it feeds.

The status bit records any loss-of-clock event that is reported while detection is armed. Detection is armed when the enable input is 1, or when a window is open after a fast wake-up from deep stop. The bit stays set until the next reset. While the window is open the bit also reads as 1, whatever the enable input says. The window closes when the oscillator reports that it is ready. In external clock mode the bit always reads 0.

Software reads the bit through a read strobe. The value returned is the one held before the clock edge of the read. So an event that lands in the same cycle as a read first shows up on the next read.

Top module: `clk_mode_status`

## Requirements
- R1: The strap code decodes to the one-hot vector {mode_xtal, mode_pll_ext, mode_1to1, mode_ext} as follows: 3'b000 gives external (0001), 3'b100 gives 1:1 PLL (0010), 3'b110 gives PLL with external reference (0100), and 3'b111 gives PLL with crystal reference (1000). Every other code decodes to external (0001).
- R2: The straps are sampled on each clock edge while rst_n is low. While rst_n is high, strap changes leave the mode outputs unchanged.
- R3: lol_pulse is high for exactly the one cycle after a reset-time sampling edge at which the strap value differs from the previous sample. This includes the value held over from before a system reset.
- R4: Once set, the status bit stays at 1 through later reads and idle cycles. Only a reset (rst_n or por_n low) clears it.
- R5: A loc_event pulse sets the status bit only when loc_en is 1 or the wake window is open.
- R6: Leaving stop (stop_active falling) with fast_wake=1 and stop_sel=2'b11 opens the wake window. While the window is open the bit reads 1 regardless of loc_en. A rising edge on osc_ready closes the window. A stop exit with any other stop_sel leaves the window closed.
- R7: In external clock mode the status bit reads 0, even after an armed loss-of-clock event.
- R8: A read (rd_en=1) returns the status value from before that clock edge. An event in the same cycle as a read becomes visible on the following read.
- R9: When por_n is low, all state is cleared: the mode is external, lol_pulse is 0 and loc_status is 0. The first reset-time sample after power-on does not raise lol_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | System reset, synchronous, active low; the straps are sampled while it is low |
| strap | input | 3 | Clock mode strap pins |
| loc_event | input | 1 | Loss-of-clock pulse from the clock monitor |
| loc_en | input | 1 | Loss-of-clock detection enable |
| stop_active | input | 1 | High while the chip is in stop mode |
| fast_wake | input | 1 | Fast wake-up option for stop exit |
| stop_sel | input | 2 | Stop depth select; 2'b11 means the oscillator and PLL are off |
| osc_ready | input | 1 | Oscillator has started and is stable |
| rd_en | input | 1 | Status read strobe |
| mode_ext | output | 1 | External clock mode |
| mode_1to1 | output | 1 | 1:1 PLL mode |
| mode_pll_ext | output | 1 | Normal PLL mode with external reference |
| mode_pll_xtal | output | 1 | Normal PLL mode with crystal reference |
| lol_pulse | output | 1 | One-cycle loss-of-lock pulse on a strap change during reset |
| loc_status | output | 1 | Status bit as returned by the last read |

## Verification
A status read and a new armed loss-of-clock event can occur in the same cycle. The bench raises rd_en and loc_event on the same falling edge, with loc_en set. It then requires that the read returns 0 and that an immediate second read returns 1, which shows the event was kept rather than lost. A second overlap sets an event inside the wake window together with the oscillator-ready rise that closes the window. The bit must still read 1 after the window has closed.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int STRAP_W = 3;
  localparam int STOP_SEL_W = 2;
  localparam int MODE_N = 4;

  typedef enum logic [1:0] {
    CM_EXT        = 2'd0,
    CM_PLL_1TO1   = 2'd1,
    CM_PLL_EXTREF = 2'd2,
    CM_PLL_XTAL   = 2'd3
  } clk_mode_e;

  // Undefined codes fall back to the external clock mode.
  function automatic clk_mode_e decode_strap(input logic [STRAP_W-1:0] code);
    case (code)
      3'b100:  return CM_PLL_1TO1;
      3'b110:  return CM_PLL_EXTREF;
      3'b111:  return CM_PLL_XTAL;
      default: return CM_EXT;
    endcase
  endfunction

  function automatic logic [MODE_N-1:0] mode_onehot(input clk_mode_e m);
    return MODE_N'(1) << m;
  endfunction

  // A stop exit opens the wake window only with fast wake-up and the deepest stop depth.
  function automatic logic deep_fast_exit(input logic fast, input logic [STOP_SEL_W-1:0] sel);
    return fast && (sel == {STOP_SEL_W{1'b1}});
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch
  import clkmode_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  output logic [STRAP_W-1:0] strap_q_o,
  output logic               change_evt_o,
  output logic               lol_o
);
  logic have_q;

  // Compare against the held sample only once a sample exists since power-on.
  assign change_evt_o = !rst_n && have_q && (strap_i != strap_q_o);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      strap_q_o <= '0;
      have_q    <= 1'b0;
      lol_o     <= 1'b0;
    end else if (!rst_n) begin
      strap_q_o <= strap_i;
      have_q    <= 1'b1;
      lol_o     <= change_evt_o;
    end else begin
      lol_o     <= 1'b0;
    end
  end
endmodule

// File: rtl/wake_window.sv
module wake_window
  import clkmode_pkg::*;
(
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  rst_n,
  input  logic                  stop_active,
  input  logic                  fast_wake,
  input  logic [STOP_SEL_W-1:0] stop_sel,
  input  logic                  osc_ready,
  output logic                  win_o,
  output logic                  open_evt_o,
  output logic                  close_evt_o
);
  logic stop_prev, osc_prev;

  assign open_evt_o  = stop_prev && !stop_active && deep_fast_exit(fast_wake, stop_sel);
  assign close_evt_o = osc_ready && !osc_prev;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      stop_prev <= 1'b0;
      osc_prev  <= 1'b0;
      win_o     <= 1'b0;
    end else if (!rst_n) begin
      stop_prev <= 1'b0;
      osc_prev  <= osc_ready;
      win_o     <= 1'b0;
    end else begin
      stop_prev <= stop_active;
      osc_prev  <= osc_ready;
      if (open_evt_o)       win_o <= 1'b1;
      else if (close_evt_o) win_o <= 1'b0;
    end
  end
endmodule

// File: rtl/loc_tracker.sv
module loc_tracker (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic loc_event,
  input  logic loc_en,
  input  logic win,
  input  logic rd_en,
  output logic detect_o,
  output logic sticky_o,
  output logic flag_now_o,
  output logic status_o
);
  assign detect_o   = loc_event && (loc_en || win);
  assign flag_now_o = !ext_mode && (sticky_o || win);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sticky_o <= 1'b0;
      status_o <= 1'b0;
    end else if (!rst_n) begin
      sticky_o <= 1'b0;
      status_o <= 1'b0;
    end else begin
      sticky_o <= !ext_mode && (sticky_o || detect_o);
      // The read takes the value from before this edge's update.
      if (rd_en) status_o <= flag_now_o;
    end
  end
endmodule

// File: rtl/clk_mode_status.sv
module clk_mode_status
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic [2:0] strap,
  input  logic       loc_event,
  input  logic       loc_en,
  input  logic       stop_active,
  input  logic       fast_wake,
  input  logic [1:0] stop_sel,
  input  logic       osc_ready,
  input  logic       rd_en,
  output logic       mode_ext,
  output logic       mode_1to1,
  output logic       mode_pll_ext,
  output logic       mode_pll_xtal,
  output logic       lol_pulse,
  output logic       loc_status
);
  logic [STRAP_W-1:0] strap_q;
  logic               strap_change;
  logic [MODE_N-1:0]  mode_oh;
  logic               wake_win, wake_open, wake_close;
  logic               loc_detect, loc_sticky, loc_flag_now;

  strap_latch u_strap (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap_i(strap),
    .strap_q_o(strap_q), .change_evt_o(strap_change), .lol_o(lol_pulse)
  );

  assign mode_oh       = mode_onehot(decode_strap(strap_q));
  assign mode_ext      = mode_oh[CM_EXT];
  assign mode_1to1     = mode_oh[CM_PLL_1TO1];
  assign mode_pll_ext  = mode_oh[CM_PLL_EXTREF];
  assign mode_pll_xtal = mode_oh[CM_PLL_XTAL];

  wake_window u_wake (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .stop_active(stop_active),
    .fast_wake(fast_wake), .stop_sel(stop_sel), .osc_ready(osc_ready),
    .win_o(wake_win), .open_evt_o(wake_open), .close_evt_o(wake_close)
  );

  loc_tracker u_loc (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ext_mode(mode_ext),
    .loc_event(loc_event), .loc_en(loc_en), .win(wake_win), .rd_en(rd_en),
    .detect_o(loc_detect), .sticky_o(loc_sticky), .flag_now_o(loc_flag_now),
    .status_o(loc_status)
  );
endmodule

// File: rtl/clk_mode_status_chk.sv
module clk_mode_status_chk (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic [3:0] mode_oh,
  input logic       strap_change,
  input logic       lol_pulse,
  input logic       wake_win,
  input logic       wake_open,
  input logic       wake_close,
  input logic       loc_detect,
  input logic       loc_sticky,
  input logic       loc_flag_now,
  input logic       rd_en,
  input logic       loc_status
);
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
    $countones(mode_oh) == 1);                                           // R1
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    rst_n && $past(rst_n) |-> $stable(mode_oh));                         // R2
  AST_LOL_FROM_CHANGE: assert property (@(posedge clk) disable iff (!por_n)
    strap_change |=> lol_pulse);                                         // R3
  AST_LOL_ONLY_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    lol_pulse |-> $past(!rst_n));                                        // R3
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    rst_n && $past(rst_n) && $past(loc_sticky) |-> loc_sticky);          // R4
  AST_DETECT_SETS: assert property (@(posedge clk) disable iff (!por_n)
    rst_n && loc_detect && !mode_oh[0] |=> loc_sticky || !rst_n);        // R5
  AST_WAKE_OPEN: assert property (@(posedge clk) disable iff (!por_n)
    rst_n && wake_open |=> wake_win || !rst_n);                          // R6
  AST_WAKE_CLOSE: assert property (@(posedge clk) disable iff (!por_n)
    rst_n && wake_close && !wake_open |=> !wake_win);                    // R6
  AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    mode_oh[0] |-> !loc_flag_now && !loc_sticky);                        // R7
  AST_READ_OLD: assert property (@(posedge clk) disable iff (!por_n)
    rst_n && rd_en |=> loc_status == $past(loc_flag_now));               // R8
  AST_POR_CLEAR: assert property (@(posedge clk)
    !por_n |-> !lol_pulse && !loc_status && mode_oh[0]);                 // R9
endmodule

bind clk_mode_status clk_mode_status_chk u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .mode_oh(mode_oh),
  .strap_change(strap_change), .lol_pulse(lol_pulse),
  .wake_win(wake_win), .wake_open(wake_open), .wake_close(wake_close),
  .loc_detect(loc_detect), .loc_sticky(loc_sticky),
  .loc_flag_now(loc_flag_now), .rd_en(rd_en), .loc_status(loc_status)
);

// File: tb/tb_clk_mode_status.sv
module tb_clk_mode_status;
  logic clk = 1'b0;
  logic por_n, rst_n, loc_event, loc_en, stop_active, fast_wake, osc_ready, rd_en;
  logic [2:0] strap;
  logic [1:0] stop_sel;
  logic mode_ext, mode_1to1, mode_pll_ext, mode_pll_xtal, lol_pulse, loc_status;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clk_mode_status dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .strap(strap),
    .loc_event(loc_event), .loc_en(loc_en), .stop_active(stop_active),
    .fast_wake(fast_wake), .stop_sel(stop_sel), .osc_ready(osc_ready),
    .rd_en(rd_en), .mode_ext(mode_ext), .mode_1to1(mode_1to1),
    .mode_pll_ext(mode_pll_ext), .mode_pll_xtal(mode_pll_xtal),
    .lol_pulse(lol_pulse), .loc_status(loc_status)
  );

  // {strap code, expected {xtal, pll_ext, 1to1, ext}}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 4'b0001}, {3'b001, 4'b0001}, {3'b010, 4'b0001}, {3'b011, 4'b0001},
    {3'b100, 4'b0010}, {3'b101, 4'b0001}, {3'b110, 4'b0100}, {3'b111, 4'b1000}
  };

  function automatic logic [3:0] modes();
    return {mode_pll_xtal, mode_pll_ext, mode_1to1, mode_ext};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read();
    rd_en = 1'b1; tick(1); rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    por_n = 0; rst_n = 0; strap = 3'b110; loc_event = 0; loc_en = 0;
    stop_active = 0; fast_wake = 0; stop_sel = 0; osc_ready = 0; rd_en = 0;
    tick(2);
    chk("R9 por mode", modes(), 4'b0001);
    chk("R9 por lol", {3'b0, lol_pulse}, 4'b0);
    chk("R9 por status", {3'b0, loc_status}, 4'b0);
    por_n = 1; tick(1);
    chk("R9 first sample no lol", {3'b0, lol_pulse}, 4'b0);
    chk("R1 first sample mode", modes(), 4'b0100);
    strap = 3'b111; tick(1);
    chk("R3 change raises lol", {3'b0, lol_pulse}, 4'b1);
    tick(1);
    chk("R3 lol one cycle", {3'b0, lol_pulse}, 4'b0);

    for (int i = 0; i < 8; i++) begin
      rst_n = 0; strap = VEC[i][6:4]; tick(2);
      rst_n = 1; tick(1);
      chk($sformatf("R1 decode %b", VEC[i][6:4]), modes(), VEC[i][3:0]);
    end

    rst_n = 0; strap = 3'b111; tick(2); rst_n = 1; tick(1);
    strap = 3'b000; tick(3);
    chk("R2 straps ignored after reset", modes(), 4'b1000);
    chk("R2 no lol after reset", {3'b0, lol_pulse}, 4'b0);

    loc_en = 0; loc_event = 1; tick(1); loc_event = 0;
    do_read();
    chk("R5 disabled event ignored", {3'b0, loc_status}, 4'b0);
    loc_en = 1; loc_event = 1; rd_en = 1; tick(1); loc_event = 0; rd_en = 0;
    chk("R8 coincident read old value", {3'b0, loc_status}, 4'b0);
    do_read();
    chk("R8 event on next read", {3'b0, loc_status}, 4'b1);
    loc_en = 0; tick(4); do_read();
    chk("R4 sticky holds", {3'b0, loc_status}, 4'b1);

    rst_n = 0; tick(1);
    chk("R3 non-por change lol", {3'b0, lol_pulse}, 4'b1);
    tick(1); rst_n = 1; tick(1);
    chk("R4 reset clears status", {3'b0, loc_status}, 4'b0);
    chk("R1 external after reset", modes(), 4'b0001);
    loc_en = 1; loc_event = 1; tick(1); loc_event = 0; loc_en = 0;
    do_read();
    chk("R7 external forces zero", {3'b0, loc_status}, 4'b0);

    rst_n = 0; strap = 3'b111; tick(2); rst_n = 1; tick(1);
    fast_wake = 1; stop_sel = 2'b11; stop_active = 1; tick(2);
    stop_active = 0; tick(1); do_read();
    chk("R6 wake window reads one", {3'b0, loc_status}, 4'b1);
    osc_ready = 1; tick(1); do_read();
    chk("R6 osc ready closes window", {3'b0, loc_status}, 4'b0);

    osc_ready = 0; stop_sel = 2'b10; stop_active = 1; tick(2);
    stop_active = 0; tick(1); do_read();
    chk("R6 other stop_sel no window", {3'b0, loc_status}, 4'b0);

    stop_sel = 2'b11; stop_active = 1; tick(2); stop_active = 0; tick(1);
    loc_event = 1; osc_ready = 1; tick(1); loc_event = 0;
    tick(1); do_read();
    chk("R5 event in window sticks", {3'b0, loc_status}, 4'b1);
    tick(3); do_read();
    chk("R4 sticky after window", {3'b0, loc_status}, 4'b1);

    por_n = 0; tick(1);
    chk("R9 por clears status", {3'b0, loc_status}, 4'b0);
    chk("R9 por clears mode", modes(), 4'b0001);
    finish_run();
  end
endmodule